// File: doc/BRIEF.md
# Three-Channel Staged Memory Copy Engine

This block copies byte ranges from one region of memory to another on behalf of three independent channels. Each channel holds a source byte address, a destination byte address, a 16-bit byte count (so one job moves at most 64 KB) and a mode bit. A channel in block mode starts as soon as it is programmed. A channel in demand mode also needs its own request pin held high before it is served. Neither address needs to be word aligned.

Channels that have work are served in rotation. Each grant moves one chunk of at most 16 bytes. The engine reads the chunk from the source into a 16-byte staging buffer, then writes it from the buffer to the destination. Byte lanes are realigned between the two address offsets, and byte enables cover the partial words at both ends. A single 32-bit memory port with a req/ack handshake carries all traffic. When a channel's count reaches zero, its busy bit drops and its sticky done flag rises. The done flag stays set until a clear pulse.

Top module: `dma3_mover`

## Requirements
- R1: After reset, mem_req is low and every bit of busy and done is low.
- R2: A block-mode job with word-aligned source and destination copies exactly prog_len bytes. No byte outside the destination range changes.
- R3: Any source offset (0..3) combined with any destination offset (0..3) and any length gives the same byte-exact copy. Byte enable bit i marks byte lane i, which is data bits 8i+7..8i of the little-endian word at byte address 4*mem_addr + i.
- R4: A chunk is read completely into the staging buffer before any of it is written. Bytes read but not yet written never exceed 16 and never go below zero.
- R5: A demand-mode channel makes no memory request while its dreq bit is low. If dreq drops during a chunk, that chunk finishes and the channel then pauses with busy still high, until dreq rises again.
- R6: When a job's last byte is written, busy for that channel falls and done rises in the same cycle. done stays high until a done_clr pulse clears it. A completion in the same cycle as a clear wins over the clear.
- R7: Programming a channel with prog_len = 0 sets its done flag on the next clock. busy stays low and no memory transaction is made.
- R8: A programming write to a channel whose busy bit is high is ignored. The running job finishes with its original addresses and count.
- R9: Eligible channels are granted one chunk at a time in rotation 0, 1, 2, 0, … and the rotation starts at channel 0 after reset.
- R10: While mem_req is high and mem_ack has not been seen, mem_req, mem_we, mem_addr, mem_be and mem_wdata hold steady.
- R11: Every request carries a non-zero, contiguous set of byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_valid | input | 1 | Load a job into channel prog_ch |
| prog_ch | input | 2 | Channel to program |
| prog_src | input | 32 | Source byte address |
| prog_dst | input | 32 | Destination byte address |
| prog_len | input | 16 | Byte count |
| prog_demand | input | 1 | 1 = demand mode, 0 = block mode |
| dreq | input | 3 | Per-channel demand request |
| done_clr | input | 3 | Per-channel clear of the done flag |
| busy | output | 3 | Channel has a job in progress |
| done | output | 3 | Sticky completion flags |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completes in this cycle |

## Verification
The copy function is swept over every pairing of the four source offsets with the four destination offsets. The lengths used are 1 to 5 bytes, one below, at and just above the 16-byte chunk size, and a three-chunk length. This separates lane-shift errors, end-mask errors and chunk-split errors from one another. The memory model varies its acknowledge latency from 0 to 2 cycles, so the held-request rule is exercised on both reads and writes. Three concurrent block jobs show the grant rotation by the order of chunk-start reads. A demand job whose request drops after the first request shows the pause at a chunk boundary. A second programming write to that same paused channel shows that the write is ignored. A zero-length job is also checked.

// File: rtl/dma3_pkg.sv
package dma3_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RD, ENG_WR} eng_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [LEN_W-1:0]  len;
  } chan_desc_t;
endpackage

// File: rtl/dma3_chan.sv
module dma3_chan
  import dma3_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       prog_hit,
  input  chan_desc_t prog_desc,
  input  logic       prog_demand,
  input  logic       dreq,
  input  logic       upd_hit,
  input  chan_desc_t upd_desc,
  input  logic       done_clr,
  output chan_desc_t desc,
  output logic       busy,
  output logic       done,
  output logic       eligible
);
  logic demand;

  always_ff @(posedge clk) begin
    if (rst) begin
      desc   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      demand <= 1'b0;
    end else begin
      if (done_clr) done <= 1'b0;
      if (prog_hit && !busy) begin
        desc   <= prog_desc;
        demand <= prog_demand;
        if (prog_desc.len == '0) done <= 1'b1;
        else                     busy <= 1'b1;
      end else if (upd_hit) begin
        desc <= upd_desc;
        if (upd_desc.len == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign eligible = busy && (!demand || dreq);
endmodule

// File: rtl/dma3_rr_arb.sv
module dma3_rr_arb #(
  parameter int N   = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_valid
);
  logic [IW-1:0] last;

  always_comb begin
    gnt_idx   = '0;
    gnt_valid = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int cand;
      cand = int'(last) + k;
      if (cand >= N) cand = cand - N;
      if (!gnt_valid && req[cand]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last <= IW'(N - 1);
    else if (take) last <= gnt_idx;
  end
endmodule

// File: rtl/dma3_engine.sv
module dma3_engine
  import dma3_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  parameter int NCH        = 3,
  localparam int IW  = $clog2(FIFO_BYTES),
  localparam int CW  = IW + 1,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gnt_valid,
  input  logic [CHW-1:0]  gnt_idx,
  input  chan_desc_t      gnt_desc,
  output logic            take,
  output logic            mem_req,
  output logic            mem_we,
  output logic [29:0]     mem_addr,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_ack,
  output logic            upd_valid,
  output logic [CHW-1:0]  upd_idx,
  output chan_desc_t      upd_desc
);
  eng_state_t        state;
  logic [CHW-1:0]    cur_ch;
  logic [ADDR_W-1:0] rd_addr, wr_addr, cur_addr;
  logic [LEN_W-1:0]  rem_len;
  logic [CW-1:0]     chunk, rd_left, wr_left, wptr, rptr;
  logic [CW-1:0]     left, room, nb, new_chunk;
  logic [1:0]        off;
  logic              last_beat;
  logic [7:0]        stage [FIFO_BYTES];
  logic [IW-1:0]     put_idx [4];
  logic [IW-1:0]     get_idx [4];

  always_comb begin
    cur_addr  = (state == ENG_WR) ? wr_addr : rd_addr;
    off       = cur_addr[1:0];
    left      = (state == ENG_WR) ? wr_left : rd_left;
    room      = CW'(4) - CW'(off);
    nb        = (left < room) ? left : room;
    last_beat = (left == nb);
    new_chunk = (gnt_desc.len > LEN_W'(FIFO_BYTES)) ? CW'(FIFO_BYTES)
                                                    : CW'(gnt_desc.len);
    for (int i = 0; i < 4; i++) begin
      put_idx[i] = IW'(wptr + CW'(i) - CW'(off));
      get_idx[i] = IW'(rptr + CW'(i) - CW'(off));
      mem_be[i]  = (state != ENG_IDLE) && (CW'(i) >= CW'(off)) &&
                   (CW'(i) < CW'(off) + nb);
      mem_wdata[8*i +: 8] = mem_be[i] ? stage[get_idx[i]] : 8'h00;
    end
  end

  assign take     = (state == ENG_IDLE) && gnt_valid;
  assign mem_req  = (state != ENG_IDLE);
  assign mem_we   = (state == ENG_WR);
  assign mem_addr = cur_addr[ADDR_W-1:2];

  assign upd_valid    = (state == ENG_WR) && mem_ack && last_beat;
  assign upd_idx      = cur_ch;
  assign upd_desc.src = rd_addr;
  assign upd_desc.dst = wr_addr + ADDR_W'(nb);
  assign upd_desc.len = rem_len - LEN_W'(chunk);

  always_ff @(posedge clk) begin
    if (state == ENG_RD && mem_ack) begin
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) stage[put_idx[i]] <= mem_rdata[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      cur_ch  <= '0;
      rd_addr <= '0;
      wr_addr <= '0;
      rem_len <= '0;
      chunk   <= '0;
      rd_left <= '0;
      wr_left <= '0;
      wptr    <= '0;
      rptr    <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: if (gnt_valid) begin
          cur_ch  <= gnt_idx;
          rd_addr <= gnt_desc.src;
          wr_addr <= gnt_desc.dst;
          rem_len <= gnt_desc.len;
          chunk   <= new_chunk;
          rd_left <= new_chunk;
          wr_left <= new_chunk;
          wptr    <= '0;
          rptr    <= '0;
          state   <= ENG_RD;
        end
        ENG_RD: if (mem_ack) begin
          rd_addr <= rd_addr + ADDR_W'(nb);
          rd_left <= rd_left - nb;
          wptr    <= wptr + nb;
          if (last_beat) state <= ENG_WR;
        end
        ENG_WR: if (mem_ack) begin
          wr_addr <= wr_addr + ADDR_W'(nb);
          wr_left <= wr_left - nb;
          rptr    <= rptr + nb;
          if (last_beat) state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma3_mover.sv
module dma3_mover
  import dma3_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int FIFO_BYTES = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_valid,
  input  logic [CHW-1:0]    prog_ch,
  input  logic [ADDR_W-1:0] prog_src,
  input  logic [ADDR_W-1:0] prog_dst,
  input  logic [LEN_W-1:0]  prog_len,
  input  logic              prog_demand,
  input  logic [NCH-1:0]    dreq,
  input  logic [NCH-1:0]    done_clr,
  output logic [NCH-1:0]    busy,
  output logic [NCH-1:0]    done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [29:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  chan_desc_t     descs [NCH];
  chan_desc_t     prog_desc, upd_desc;
  logic [NCH-1:0] eligible;
  logic [CHW-1:0] gnt_idx, upd_idx;
  logic           gnt_valid, take, upd_valid;

  assign prog_desc = '{src: prog_src, dst: prog_dst, len: prog_len};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma3_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .prog_hit   (prog_valid && prog_ch == CHW'(c)),
      .prog_desc  (prog_desc),
      .prog_demand(prog_demand),
      .dreq       (dreq[c]),
      .upd_hit    (upd_valid && upd_idx == CHW'(c)),
      .upd_desc   (upd_desc),
      .done_clr   (done_clr[c]),
      .desc       (descs[c]),
      .busy       (busy[c]),
      .done       (done[c]),
      .eligible   (eligible[c])
    );
  end

  dma3_rr_arb #(.N(NCH)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .req      (eligible),
    .take     (take),
    .gnt_idx  (gnt_idx),
    .gnt_valid(gnt_valid)
  );

  dma3_engine #(.FIFO_BYTES(FIFO_BYTES), .NCH(NCH)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .gnt_valid(gnt_valid),
    .gnt_idx  (gnt_idx),
    .gnt_desc (descs[gnt_idx]),
    .take     (take),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .mem_ack  (mem_ack),
    .upd_valid(upd_valid),
    .upd_idx  (upd_idx),
    .upd_desc (upd_desc)
  );
endmodule

// File: rtl/dma3_sva.sv
module dma3_sva #(
  parameter int NCH = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           prog_valid,
  input logic [CHW-1:0] prog_ch,
  input logic [15:0]    prog_len,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] done,
  input logic           mem_req,
  input logic           mem_we,
  input logic [29:0]    mem_addr,
  input logic [3:0]     mem_be,
  input logic [31:0]    mem_wdata,
  input logic           mem_ack
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mem_req && busy == '0 && done == '0));

  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_be) && $stable(mem_wdata)));

  a_r11_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_be != 4'b0000));

  a_r11_be_contiguous: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011,
                                4'b0110, 4'b1100, 4'b0111, 4'b1110, 4'b1111}));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r6_done_on_finish: assert property (@(posedge clk) disable iff (rst)
      $fell(busy[c]) |-> done[c]);

    a_r7_zero_len: assert property (@(posedge clk) disable iff (rst)
      (prog_valid && prog_ch == CHW'(c) && prog_len == 16'd0 && !busy[c])
        |=> (done[c] && !busy[c]));
  end
endmodule

bind dma3_mover dma3_sva #(.NCH(NCH)) u_sva (.*);

// File: tb/dma3_mover_tb.sv
module dma3_mover_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        prog_valid;
  logic [1:0]  prog_ch;
  logic [31:0] prog_src, prog_dst;
  logic [15:0] prog_len;
  logic        prog_demand;
  logic [2:0]  dreq, done_clr, busy, done;
  logic        mem_req, mem_we, mem_ack;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  logic [7:0] mem [1024];
  logic [7:0] expm [1024];
  int wcnt = 0, lat = 0, outst = 0, max_out = 0, min_out = 0;
  int req_seen = 0;
  bit last_wr = 1'b1;
  int log_q [16];
  int log_n = 0;

  always #10 clk = ~clk;

  dma3_mover u_dut (.*);

  always @(negedge clk) begin
    if (rst || !mem_req) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (wcnt >= lat) begin
      int base, nby;
      mem_ack = 1'b1;
      wcnt = 0;
      lat = (lat + 1) % 3;
      req_seen++;
      base = (int'(mem_addr) * 4) & 1023;
      nby = $countones(mem_be);
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[base + i] = mem_wdata[8*i +: 8];
        outst -= nby;
        last_wr = 1'b1;
      end else begin
        for (int i = 0; i < 4; i++) mem_rdata[8*i +: 8] = mem[base + i];
        if (last_wr && log_n < 16) begin
          log_q[log_n] = base / 128;
          log_n++;
        end
        last_wr = 1'b0;
        outst += nby;
      end
      if (outst > max_out) max_out = outst;
      if (outst < min_out) min_out = outst;
    end else begin
      mem_ack = 1'b0;
      wcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  task automatic mem_init();
    for (int a = 0; a < 1024; a++) begin
      mem[a] = pat(a);
      expm[a] = pat(a);
    end
  endtask

  task automatic exp_copy(input int s, input int d, input int n);
    for (int k = 0; k < n; k++) expm[d + k] = pat(s + k);
  endtask

  task automatic exp_check(input string tag);
    int bad = 0, first = -1;
    for (int a = 0; a < 1024; a++)
      if (mem[a] !== expm[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    chk(bad == 0, tag, bad, 0);
    if (bad != 0) $display("  first mismatch at byte %0d: %0h vs %0h", first, mem[first], expm[first]);
  endtask

  task automatic prog(input int ch, input int s, input int d, input int n, input bit dm);
    @(negedge clk);
    prog_valid = 1'b1; prog_ch = 2'(ch); prog_src = 32'(s);
    prog_dst = 32'(d); prog_len = 16'(n); prog_demand = dm;
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  task automatic wait_done(input int ch, input string tag);
    int t = 0;
    while (!done[ch] && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(done[ch] == 1'b1, tag, done[ch], 1);
  endtask

  task automatic clear_done(input int ch);
    @(negedge clk);
    done_clr[ch] = 1'b1;
    @(negedge clk);
    done_clr = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lens [9] = '{1, 2, 3, 4, 5, 15, 16, 17, 33};
    int r0;
    rst = 1'b1; prog_valid = 1'b0; prog_ch = '0; prog_src = '0; prog_dst = '0;
    prog_len = '0; prog_demand = 1'b0; dreq = '0; done_clr = '0; mem_rdata = '0;
    mem_init();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_req == 1'b0 && busy == 3'b000 && done == 3'b000, "R1 reset",
        {mem_req, busy, done}, 0);
    rst = 1'b0;

    // R2/R3 sweep of offsets and lengths, R4 staging bound
    for (int so = 0; so < 4; so++)
      for (int d_o = 0; d_o < 4; d_o++)
        for (int li = 0; li < 9; li++) begin
          string tag;
          tag = (so == 0 && d_o == 0) ? "R2 aligned copy" : "R3 unaligned copy";
          mem_init();
          exp_copy(64 + so, 512 + d_o, lens[li]);
          prog(li % 3, 64 + so, 512 + d_o, lens[li], 1'b0);
          wait_done(li % 3, "R6 done rises");
          exp_check(tag);
          chk(busy == 3'b000, "R6 busy cleared", busy, 0);
          clear_done(li % 3);
        end
    chk(max_out <= 16 && min_out >= 0, "R4 staged bytes in range", max_out, 16);

    // R6 sticky done and clear
    mem_init();
    exp_copy(10, 600, 7);
    prog(2, 10, 600, 7, 1'b0);
    wait_done(2, "R6 done");
    repeat (6) @(negedge clk);
    chk(done[2] == 1'b1, "R6 done sticky", done[2], 1);
    clear_done(2);
    chk(done[2] == 1'b0, "R6 done cleared", done[2], 0);
    exp_check("R6 copy");

    // R7 zero length
    r0 = req_seen;
    prog(1, 100, 700, 0, 1'b0);
    chk(done[1] == 1'b1 && busy[1] == 1'b0, "R7 zero length done", {busy[1], done[1]}, 1);
    repeat (10) @(negedge clk);
    chk(req_seen == r0 && mem_req == 1'b0, "R7 no traffic", req_seen - r0, 0);
    clear_done(1);

    // R5 demand mode waits for dreq
    mem_init();
    r0 = req_seen;
    prog(1, 300, 900, 20, 1'b1);
    repeat (40) @(negedge clk);
    chk(req_seen == r0 && mem_req == 1'b0 && busy[1], "R5 idle without dreq",
        req_seen - r0, 0);
    dreq[1] = 1'b1;
    while (!mem_req) @(negedge clk);
    dreq[1] = 1'b0;
    repeat (80) @(negedge clk);
    exp_copy(300, 900, 16);
    exp_check("R5 pause after one chunk");
    chk(busy[1] == 1'b1 && done[1] == 1'b0, "R5 still busy", busy[1], 1);
    // R8 reprogram while busy is ignored
    prog(1, 0, 700, 8, 1'b0);
    dreq[1] = 1'b1;
    wait_done(1, "R5 resume done");
    dreq[1] = 1'b0;
    exp_copy(300, 900, 20);
    exp_check("R8 reprogram ignored, original job done");
    clear_done(1);

    // R9 round robin across three block jobs
    mem_init();
    log_n = 0;
    last_wr = 1'b1;
    prog(0, 0, 520, 40, 1'b0);
    prog(1, 128, 660, 40, 1'b0);
    prog(2, 256, 800, 40, 1'b0);
    wait_done(0, "R9 ch0 done");
    wait_done(1, "R9 ch1 done");
    wait_done(2, "R9 ch2 done");
    exp_copy(0, 520, 40);
    exp_copy(128, 660, 40);
    exp_copy(256, 800, 40);
    exp_check("R9 three copies");
    chk(log_n == 9, "R9 chunk count", log_n, 9);
    for (int k = 0; k < 9; k++)
      chk(log_q[k] == k % 3, "R9 grant order", log_q[k], k % 3);
    chk(max_out <= 16 && min_out >= 0, "R4 staged bytes in range", max_out, 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule